// File: doc/BRIEF.md
# Tamper Input Detector

This block watches one external tamper pad and raises a sticky tamper flag when the pad shows an intrusion. First the pad goes through a two-stage synchronizer. The block then works in one of two ways. Which one is set by the filter code.

With a filter code of zero, the block detects edges. A single synchronized transition in the chosen direction is a tamper event.

With a non-zero filter code, the block detects levels. A prescaler makes a sampling tick every 2^(BASE_LOG2 - freq_code) clock cycles. At each tick the sequencer drives a pull-up pre-charge for 2^prech_code cycles and then takes one sample. When 2^filter_code samples in a row read the active level, that is a tamper event.

The sequencer has three states:
- IDLE waits for a tick.
- PRECHARGE drives the pad pull-up and counts out the pre-charge time.
- SAMPLE judges the pad for one cycle.

Its transitions are:
- IDLE to PRECHARGE on a tick in level mode.
- PRECHARGE to SAMPLE when the pre-charge count is complete.
- PRECHARGE to IDLE when level mode is left.
- SAMPLE to IDLE always.

An event sets the flag. If enabled, it also pulses a timestamp-capture strobe and raises an interrupt request. The flag stays set until software clears it, and it masks any further events.

Top module: `tamper_detect`

## Requirements
- R1: After reset, tamper_flag, irq, ts_strobe and pullup_en are all 0.
- R2: With cfg_filt = 0, cfg_pol = 0 selects a rising pad edge and cfg_pol = 1 a falling edge. The opposite edge has no effect. After a pad change, tamper_flag rises at the third rising clock edge (two synchronizer stages, then the flag register).
- R3: With cfg_filt != 0, a sampling tick occurs every P = 2^(BASE_LOG2 - cfg_freq) cycles, counted from the first clock edge on which cfg_filt is non-zero. With the default BASE_LOG2 = 15, codes 0..7 give 32768 down to 256 cycles.
- R4: Each tick starts a pre-charge of D = 2^cfg_prech cycles, with pullup_en high for exactly those cycles. The sample is taken in the following cycle. The first sample therefore lands on edge P + D + 1 after entry to level mode.
- R5: With cfg_filt = n > 0, the pad is active when it equals cfg_pol (0 means low is active). The event needs N = 2^n consecutive active samples, so tamper_flag rises on edge N*P + D + 1.
- R6: A sample that reads inactive returns the consecutive-sample count to zero.
- R7: With cfg_pu_off = 1, pullup_en stays 0 while sampling continues as usual.
- R8: tamper_flag stays set until a flag_clr pulse. While it is set, no new event occurs and ts_strobe stays low.
- R9: ts_strobe is a one-cycle pulse on the edge where tamper_flag rises, and only when cfg_ts_en = 1.
- R10: irq is high exactly while tamper_flag is set and cfg_irq_en = 1, and follows either with one register of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Detector clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_in | input | 1 | Raw tamper pad level |
| cfg_freq | input | FREQ_W | Sampling rate code |
| cfg_filt | input | FILT_W | Filter code; 0 selects edge mode |
| cfg_prech | input | PRE_W | Pre-charge length code |
| cfg_pol | input | 1 | Active edge (edge mode) or active level (level mode) |
| cfg_pu_off | input | 1 | 1 disables the pre-charge pull-up |
| cfg_irq_en | input | 1 | Interrupt request enable |
| cfg_ts_en | input | 1 | Timestamp strobe enable |
| flag_clr | input | 1 | Clears the tamper flag |
| tamper_flag | output | 1 | Sticky tamper flag |
| irq | output | 1 | Interrupt request |
| ts_strobe | output | 1 | Timestamp-capture pulse |
| pullup_en | output | 1 | Pad pull-up control |

## Verification
The bench builds the block with BASE_LOG2 = 8. This makes sampling periods of 256 down to 16 cycles short enough that every combination of frequency codes 0 to 4, all four pre-charge lengths, all three filter depths and both polarities can be swept in full. For each combination the bench computes the exact edge where the flag should rise and the exact number of pull-up cycles, then compares both. A separate run breaks the chain of active samples and then counts on from zero. Edge mode is covered by both polarities, the ignored opposite edge, and the enable gating of the strobe and interrupt.

// File: rtl/tamper_pkg.sv
package tamper_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PRECH  = 2'd1,
        ST_SAMPLE = 2'd2
    } tamp_state_e;
endpackage

// File: rtl/tamper_sync.sv
module tamper_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tamper_prescaler.sv
module tamper_prescaler #(
    parameter int BASE_LOG2 = 15,
    parameter int FREQ_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [FREQ_W-1:0] code,
    output logic              tick
);
    logic [BASE_LOG2-1:0] cnt;
    logic [BASE_LOG2-1:0] mask;

    // Period 2^(BASE_LOG2 - code): the low bits of the count wrap at that rate.
    always_comb mask = {BASE_LOG2{1'b1}} >> code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (!run) cnt <= '0;
        else          cnt <= cnt + 1'b1;
    end

    assign tick = run && ((cnt & mask) == mask);
endmodule

// File: rtl/tamper_seq.sv
module tamper_seq
    import tamper_pkg::*;
#(
    parameter int FILT_W = 2,
    parameter int PRE_W  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp,
    input  logic             tick,
    input  logic [FILT_W-1:0] cfg_filt,
    input  logic [PRE_W-1:0] cfg_prech,
    input  logic             cfg_pol,
    input  logic             cfg_pu_off,
    input  logic             cfg_irq_en,
    input  logic             cfg_ts_en,
    input  logic             flag_clr,
    output logic             tamper_flag,
    output logic             irq,
    output logic             ts_strobe,
    output logic             pullup_en
);
    localparam int PCNT_W = 1 << PRE_W;
    localparam int HCNT_W = 1 << FILT_W;

    tamp_state_e       state, state_n;
    logic [PCNT_W-1:0] pcnt, pre_len;
    logic [HCNT_W-1:0] hits, hits_inc, hit_goal;
    logic              smp_prev;
    logic              run, pre_last, active;
    logic              level_evt, edge_evt, evt, flag_d;

    always_comb begin
        run       = (cfg_filt != '0);
        pre_len   = PCNT_W'(1) << cfg_prech;
        pre_last  = (pcnt == pre_len - 1'b1);
        hit_goal  = HCNT_W'(1) << cfg_filt;
        hits_inc  = hits + 1'b1;
        active    = (smp == cfg_pol);
        level_evt = (state == ST_SAMPLE) && run && active && (hits_inc == hit_goal);
        edge_evt  = !run && (smp != smp_prev) && (smp != cfg_pol);
        evt       = (level_evt || edge_evt) && !tamper_flag;
        flag_d    = flag_clr ? 1'b0 : (tamper_flag || evt);
    end

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (run && tick) state_n = ST_PRECH;
            ST_PRECH:  if (!run)        state_n = ST_IDLE;
                       else if (pre_last) state_n = ST_SAMPLE;
            ST_SAMPLE: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Pre-charge timer, run-length counter, edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt     <= '0;
            hits     <= '0;
            smp_prev <= 1'b0;
        end else begin
            smp_prev <= smp;
            pcnt     <= (state == ST_PRECH) ? pcnt + 1'b1 : '0;
            if (!run || tamper_flag)      hits <= '0;
            else if (state == ST_SAMPLE) begin
                if (level_evt)            hits <= '0;
                else if (active)          hits <= hits_inc;
                else                      hits <= '0;
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tamper_flag <= 1'b0;
            irq         <= 1'b0;
            ts_strobe   <= 1'b0;
            pullup_en   <= 1'b0;
        end else begin
            tamper_flag <= flag_d;
            irq         <= flag_d && cfg_irq_en;
            ts_strobe   <= evt && cfg_ts_en;
            pullup_en   <= (state_n == ST_PRECH) && !cfg_pu_off;
        end
    end

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tamper_flag && !flag_clr |=> tamper_flag);
    assert_ts_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ts_strobe |=> !ts_strobe);
    assert_ts_with_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ts_strobe |-> tamper_flag && $rose(tamper_flag));
    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> tamper_flag);
    assert_pullup_in_prech_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pullup_en |-> state == ST_PRECH);
    assert_pullup_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pullup_en |-> !$past(cfg_pu_off));
endmodule

// File: rtl/tamper_detect.sv
module tamper_detect #(
    parameter int BASE_LOG2   = 15,
    parameter int FREQ_W      = 3,
    parameter int FILT_W      = 2,
    parameter int PRE_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pad_in,
    input  logic [FREQ_W-1:0] cfg_freq,
    input  logic [FILT_W-1:0] cfg_filt,
    input  logic [PRE_W-1:0]  cfg_prech,
    input  logic              cfg_pol,
    input  logic              cfg_pu_off,
    input  logic              cfg_irq_en,
    input  logic              cfg_ts_en,
    input  logic              flag_clr,
    output logic              tamper_flag,
    output logic              irq,
    output logic              ts_strobe,
    output logic              pullup_en
);
    logic pad_s;
    logic tick;
    logic level_mode;

    assign level_mode = (cfg_filt != '0);

    tamper_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pad_s)
    );

    tamper_prescaler #(.BASE_LOG2(BASE_LOG2), .FREQ_W(FREQ_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(level_mode), .code(cfg_freq), .tick(tick)
    );

    tamper_seq #(.FILT_W(FILT_W), .PRE_W(PRE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .smp(pad_s), .tick(tick),
        .cfg_filt(cfg_filt), .cfg_prech(cfg_prech), .cfg_pol(cfg_pol),
        .cfg_pu_off(cfg_pu_off), .cfg_irq_en(cfg_irq_en), .cfg_ts_en(cfg_ts_en),
        .flag_clr(flag_clr), .tamper_flag(tamper_flag), .irq(irq),
        .ts_strobe(ts_strobe), .pullup_en(pullup_en)
    );
endmodule

// File: tb/tb_tamper_detect.sv
module tb_tamper_detect;
    localparam int BASE = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, pad_in, cfg_pol, cfg_pu_off, cfg_irq_en, cfg_ts_en, flag_clr;
    logic [2:0] cfg_freq;
    logic [1:0] cfg_filt, cfg_prech;
    logic       tamper_flag, irq, ts_strobe, pullup_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    tamper_detect #(.BASE_LOG2(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .cfg_freq(cfg_freq),
        .cfg_filt(cfg_filt), .cfg_prech(cfg_prech), .cfg_pol(cfg_pol),
        .cfg_pu_off(cfg_pu_off), .cfg_irq_en(cfg_irq_en), .cfg_ts_en(cfg_ts_en),
        .flag_clr(flag_clr), .tamper_flag(tamper_flag), .irq(irq),
        .ts_strobe(ts_strobe), .pullup_en(pullup_en)
    );

    task automatic check_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        wait_n(1);
        flag_clr = 1'b0;
        wait_n(1);
    endtask

    // Level mode: flag expected on edge N*P + D + 1 (R3, R4, R5, R7)
    task automatic run_level(int pol, int filt, int freq, int pre, int pu);
        int p, d, n, pcount, tcount;
        cfg_filt = 2'd0;
        cfg_pol  = pol[0];
        wait_n(1);
        pad_in = pol[0];
        wait_n(4);
        clear_flag();
        cfg_freq = 3'(freq); cfg_prech = 2'(pre); cfg_pu_off = pu[0];
        cfg_irq_en = 1'b1;   cfg_ts_en = 1'b1;
        p = 1 << (BASE - freq);
        d = 1 << pre;
        n = 1 << filt;
        pcount = 0; tcount = 0;
        cfg_filt = 2'(filt);
        for (int c = 1; c <= n * p + d; c++) begin
            @(negedge clk);
            pcount += int'(pullup_en);
            tcount += int'(ts_strobe);
        end
        check_eq("R5 flag before final sample", int'(tamper_flag) + tcount, 0);
        check_eq(pu ? "R7 pullup count" : "R4 pullup count", pcount, pu ? 0 : n * d);
        wait_n(1);
        check_eq("R3 R5 flag at computed edge", int'(tamper_flag), 1);
        check_eq("R9 strobe at level event", int'(ts_strobe), 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int tc;
        rst_n = 1'b0; pad_in = 1'b0; cfg_pol = 1'b0; cfg_pu_off = 1'b0;
        cfg_irq_en = 1'b1; cfg_ts_en = 1'b1; flag_clr = 1'b0;
        cfg_freq = 3'd0; cfg_filt = 2'd0; cfg_prech = 2'd0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);
        check_eq("R1 reset flag", int'(tamper_flag), 0);
        check_eq("R1 reset irq", int'(irq), 0);
        check_eq("R1 reset strobe", int'(ts_strobe), 0);
        check_eq("R1 reset pullup", int'(pullup_en), 0);

        // Edge mode, rising active (R2, R9, R10)
        pad_in = 1'b1;
        wait_n(2);
        check_eq("R2 rising not yet", int'(tamper_flag), 0);
        wait_n(1);
        check_eq("R2 rising edge detected", int'(tamper_flag), 1);
        check_eq("R9 strobe on event", int'(ts_strobe), 1);
        check_eq("R10 irq with flag", int'(irq), 1);
        wait_n(1);
        check_eq("R9 strobe one cycle", int'(ts_strobe), 0);

        // Sticky and suppression (R8)
        pad_in = 1'b0;
        tc = 0;
        for (int i = 0; i < 10; i++) begin wait_n(1); tc += int'(ts_strobe); end
        pad_in = 1'b1;
        for (int i = 0; i < 10; i++) begin wait_n(1); tc += int'(ts_strobe); end
        check_eq("R8 flag sticky", int'(tamper_flag), 1);
        check_eq("R8 no strobe while set", tc, 0);
        flag_clr = 1'b1; wait_n(1); flag_clr = 1'b0;
        check_eq("R8 flag cleared", int'(tamper_flag), 0);
        check_eq("R10 irq drops with flag", int'(irq), 0);

        // Falling edge ignored with rising polarity (R2)
        pad_in = 1'b0;
        wait_n(6);
        check_eq("R2 falling ignored pol0", int'(tamper_flag), 0);

        // Falling polarity (R2, R9, R10)
        cfg_pol = 1'b1;
        wait_n(1);
        pad_in = 1'b1;
        wait_n(6);
        check_eq("R2 rising ignored pol1", int'(tamper_flag), 0);
        cfg_ts_en = 1'b0; cfg_irq_en = 1'b0;
        pad_in = 1'b0;
        wait_n(3);
        check_eq("R2 falling edge detected", int'(tamper_flag), 1);
        check_eq("R9 strobe gated off", int'(ts_strobe), 0);
        check_eq("R10 irq gated off", int'(irq), 0);
        cfg_irq_en = 1'b1;
        wait_n(1);
        check_eq("R10 irq follows enable", int'(irq), 1);
        clear_flag();

        // Level mode sweep (R3, R4, R5, R7, R9)
        for (int pol = 0; pol < 2; pol++)
            for (int filt = 1; filt < 4; filt++)
                for (int freq = 0; freq < 5; freq++)
                    for (int pre = 0; pre < 4; pre++)
                        run_level(pol, filt, freq, pre, (freq + pre + pol) % 2);

        // Broken run restarts the count (R6): P=32, D=1, N=4, low active
        cfg_filt = 2'd0; cfg_pol = 1'b0;
        wait_n(1);
        pad_in = 1'b0;
        wait_n(4);
        clear_flag();
        cfg_freq = 3'd3; cfg_prech = 2'd0; cfg_pu_off = 1'b0; cfg_ts_en = 1'b1;
        cfg_filt = 2'd2;
        wait_n(37);
        pad_in = 1'b1;
        wait_n(32);
        pad_in = 1'b0;
        wait_n(193 - 69);
        check_eq("R6 count restarted, not yet", int'(tamper_flag), 0);
        wait_n(1);
        check_eq("R6 flag after four fresh samples", int'(tamper_flag), 1);
        tc = 0;
        for (int i = 0; i < 100; i++) begin wait_n(1); tc += int'(ts_strobe); end
        check_eq("R8 no level event while set", tc, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule